// File: doc/BRIEF.md
# Core Idle-Depth Power Sequencer

This block is the per-core sequencer that moves a processor core between running and one of five idle depths. Software picks a target depth on a 3-bit select input. The core then issues a wait-for-interrupt or wait-for-event request. The sequencer drives the core clock enable, the logic and cache power enables, the coherence isolation, the retention enable and the core reset. It also reports the current depth on a status code.

The two shallow depths only stop the clock. Standby leaves everything powered. Retention also asserts a retention enable. The three deep depths first isolate the core from the coherence domain, with the clock still running. They then wait for a save-done acknowledge and remove logic power. Dormant keeps the cache arrays powered, while power-down and hot-unplug remove both. A combinational wake monitor runs from the free-running clock domain and merges four wake sources: interrupt, event, send-event and snoop request.

Power-up waits for a power-good acknowledge from the switch, then holds reset for a parameterised number of cycles before the core runs again. A wake that arrives during isolation aborts the entry without a reset. A hot-unplugged core responds only to an explicit bring-up command.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the status code is 0, clk_en, logic_pwr_en and cache_pwr_en are 1, and coh_iso, core_rst and ret_en are 0.
- R2: In run, a wfi_req or wfe_req with depth_sel equal to 1 (or any unsupported code 0, 6, 7) enters standby on the next cycle: clk_en 0, status 1, both power enables stay 1, ret_en 0.
- R3: With depth_sel 2 the entry is the same as standby except that the status is 2 and ret_en is 1 for as long as the clock is stopped.
- R4: In standby or retention, any one of irq, evt, sev or snoop_req sampled high at clock edge k leaves clk_en at 0 after edge k and sets clk_en 1 with status 0 after edge k+1.
- R5: With depth_sel 3, 4 or 5 the first entry step asserts coh_iso while clk_en and logic_pwr_en stay 1. Logic power is removed only on the cycle after save_done is sampled high.
- R6: While logic power is off, cache_pwr_en stays 1 for depth 3 (dormant) and is 0 for depths 4 and 5.
- R7: For depths 3 and 4, a wake source sampled during isolation returns the core to run on the next cycle with core_rst never asserted, even if save_done is high in the same cycle.
- R8: For depth 5 (hot-unplug), all four wake sources are ignored during isolation and while powered off. Only bring_up starts power-up.
- R9: When the core is woken from power-off, logic_pwr_en returns to 1 while core_rst and coh_iso stay 1 and clk_en stays 0 until pwr_good is sampled high.
- R10: After pwr_good is sampled, core_rst stays high with clk_en 1 for exactly RST_HOLD cycles (default 8). Then status is 0 and coh_iso and core_rst are 0.
- R11: The status code is 0 in run and otherwise equals the selected depth (1 standby, 2 retention, 3 dormant, 4 power-down, 5 hot-unplug), including during wake-up and power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt entry request |
| wfe_req | input | 1 | Wait-for-event entry request |
| depth_sel | input | 3 | Target idle depth chosen by software |
| irq | input | 1 | Interrupt wake source |
| evt | input | 1 | Event wake source |
| sev | input | 1 | Send-event wake source |
| snoop_req | input | 1 | Coherency request wake source |
| bring_up | input | 1 | Explicit bring-up command for hot-unplug |
| save_done | input | 1 | State save finished acknowledge |
| pwr_good | input | 1 | Power switch good acknowledge |
| clk_en | output | 1 | Core clock enable |
| ret_en | output | 1 | Retention enable |
| logic_pwr_en | output | 1 | Core logic power enable |
| cache_pwr_en | output | 1 | Cache RAM power enable |
| coh_iso | output | 1 | Coherence isolation |
| core_rst | output | 1 | Core reset |
| state_code | output | 3 | Current state code |

## Verification
Most internal state errors show up on the status code and the enables within one cycle of the faulty transition. A wrong latched depth shows up at once as the wrong status code or the wrong cache power. A wrong sequencer state shows up as a wrong clk_en, isolation or power value on the next sampled cycle. A reset-hold counter error is the slowest to show: it appears only when reset falls early or late, at most RST_HOLD cycles after power-good. The bench counts reset-high cycles exactly to catch it.

// File: rtl/cpsq_pkg.sv
// Shared types for the core idle-depth sequencer.
// Assumes depth codes are fixed by the status encoding.
package cpsq_pkg;
    typedef enum logic [2:0] {
        D_RUN    = 3'd0,
        D_STBY   = 3'd1,
        D_RET    = 3'd2,
        D_DORM   = 3'd3,
        D_PDN    = 3'd4,
        D_UNPLUG = 3'd5
    } depth_e;

    typedef enum logic [2:0] {
        S_RUN, S_CLKOFF, S_CLKWAKE, S_ISOL, S_OFF, S_PWRUP, S_RSTHOLD
    } seq_e;

    // Map a software select to a supported idle depth; unknown codes act as standby.
    function automatic depth_e decode_depth(input logic [2:0] code);
        case (code)
            3'd2:    decode_depth = D_RET;
            3'd3:    decode_depth = D_DORM;
            3'd4:    decode_depth = D_PDN;
            3'd5:    decode_depth = D_UNPLUG;
            default: decode_depth = D_STBY;
        endcase
    endfunction
endpackage

// File: rtl/cpsq_wake_mon.sv
// Wake monitor: merges the wake sources from the always-on domain.
// In hot-unplug mode it masks every source and passes only bring-up.
// Assumes all inputs are already synchronous to the free-running clock.
module cpsq_wake_mon (
    input  logic irq,
    input  logic evt,
    input  logic sev,
    input  logic snoop_req,
    input  logic bring_up,
    input  logic unplugged,
    output logic wake,
    output logic up_cmd
);
    // Combine sources; unplugged cores see none of them.
    always_comb begin
        wake   = (irq | evt | sev | snoop_req) & ~unplugged;
        up_cmd = bring_up & unplugged;
    end
endmodule

// File: rtl/cpsq_rst_hold.sv
// Reset hold timer: counts HOLD cycles while run is high, flags the last one.
// Assumes run stays high until done is seen, then drops.
module cpsq_rst_hold #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] cnt;

    // Count cycles spent holding reset; clear whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!done)     cnt <= cnt + CW'(1);
    end

    assign done = run && (cnt == CW'(HOLD - 1));

    // R10: while holding, each cycle advances the count by one
    p_hold_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |=> (run && cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/core_pwr_seq.sv
// Per-core idle-depth sequencer. Latches the target depth at entry and walks
// clock stop, isolation, power removal, power-up and reset hold.
// Assumes save_done and pwr_good are level acknowledges from the power switch.
module core_pwr_seq
    import cpsq_pkg::*;
#(
    parameter int RST_HOLD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_req,
    input  logic       wfe_req,
    input  logic [2:0] depth_sel,
    input  logic       irq,
    input  logic       evt,
    input  logic       sev,
    input  logic       snoop_req,
    input  logic       bring_up,
    input  logic       save_done,
    input  logic       pwr_good,
    output logic       clk_en,
    output logic       ret_en,
    output logic       logic_pwr_en,
    output logic       cache_pwr_en,
    output logic       coh_iso,
    output logic       core_rst,
    output logic [2:0] state_code
);
    seq_e   state, state_n;
    depth_e depth_q, depth_n;
    logic   wake, up_cmd, hold_done, unplugged;

    assign unplugged = (depth_q == D_UNPLUG) && (state != S_RUN);

    cpsq_wake_mon u_wake (
        .irq(irq), .evt(evt), .sev(sev), .snoop_req(snoop_req),
        .bring_up(bring_up), .unplugged(unplugged),
        .wake(wake), .up_cmd(up_cmd)
    );

    cpsq_rst_hold #(.HOLD(RST_HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(state == S_RSTHOLD), .done(hold_done)
    );

    // Next-state selection for the idle sequence.
    always_comb begin
        state_n = state;
        depth_n = depth_q;
        case (state)
            S_RUN: if (wfi_req || wfe_req) begin
                depth_n = decode_depth(depth_sel);
                state_n = (depth_n == D_STBY || depth_n == D_RET) ? S_CLKOFF : S_ISOL;
            end
            S_CLKOFF:  if (wake) state_n = S_CLKWAKE;
            S_CLKWAKE: state_n = S_RUN;
            S_ISOL: begin
                if (wake)           state_n = S_RUN;
                else if (save_done) state_n = S_OFF;
            end
            S_OFF:     if (wake || up_cmd) state_n = S_PWRUP;
            S_PWRUP:   if (pwr_good) state_n = S_RSTHOLD;
            S_RSTHOLD: if (hold_done) state_n = S_RUN;
            default:   state_n = S_RUN;
        endcase
    end

    // State and latched depth registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_RUN;
            depth_q <= D_STBY;
        end else begin
            state   <= state_n;
            depth_q <= depth_n;
        end
    end

    // Output decode from the current state and latched depth.
    always_comb begin
        clk_en       = (state == S_RUN) || (state == S_ISOL) || (state == S_RSTHOLD);
        ret_en       = ((state == S_CLKOFF) || (state == S_CLKWAKE)) && (depth_q == D_RET);
        logic_pwr_en = (state != S_OFF);
        cache_pwr_en = (state != S_OFF) || (depth_q == D_DORM);
        coh_iso      = (state == S_ISOL) || (state == S_OFF) ||
                       (state == S_PWRUP) || (state == S_RSTHOLD);
        core_rst     = (state == S_OFF) || (state == S_PWRUP) || (state == S_RSTHOLD);
        state_code   = (state == S_RUN) ? 3'd0 : 3'(depth_q);
    end

    // R5: logic power only drops after a cycle of isolation
    p_iso_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(logic_pwr_en) |-> ($past(coh_iso) && coh_iso));
    // R9: reset is never driven without isolation
    p_rst_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> coh_iso);
    // R4: the wake cycle is always followed by a running clock
    p_wake_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLKWAKE) |=> (state == S_RUN && clk_en));
    // R8: an unplugged core stays off without bring-up
    p_unplug_deaf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF && depth_q == D_UNPLUG && !bring_up) |=> (state == S_OFF));
    // R7: a wake during isolation returns to run with no reset
    p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISOL && depth_q != D_UNPLUG && (irq || evt || sev || snoop_req))
        |=> (state == S_RUN && !core_rst));
endmodule

// File: tb/tb_core_pwr_seq.sv
module tb_core_pwr_seq;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, irq = 0, evt = 0, sev = 0, snoop_req = 0;
    logic bring_up = 0, save_done = 0, pwr_good = 0;
    logic [2:0] depth_sel = 3'd0;
    logic clk_en, ret_en, logic_pwr_en, cache_pwr_en, coh_iso, core_rst;
    logic [2:0] state_code;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    core_pwr_seq #(.RST_HOLD(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
        .depth_sel(depth_sel), .irq(irq), .evt(evt), .sev(sev),
        .snoop_req(snoop_req), .bring_up(bring_up), .save_done(save_done),
        .pwr_good(pwr_good), .clk_en(clk_en), .ret_en(ret_en),
        .logic_pwr_en(logic_pwr_en), .cache_pwr_en(cache_pwr_en),
        .coh_iso(coh_iso), .core_rst(core_rst), .state_code(state_code)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_src(input int s, input logic v);
        case (s)
            0: irq = v;
            1: evt = v;
            2: sev = v;
            default: snoop_req = v;
        endcase
    endtask

    task automatic enter(input int d, input int use_wfe);
        @(negedge clk);
        depth_sel = 3'(d);
        if (use_wfe != 0) wfe_req = 1; else wfi_req = 1;
        @(negedge clk);
        wfi_req = 0;
        wfe_req = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values
        check("R1 code", state_code, 0);
        check("R1 clk_en", clk_en, 1);
        check("R1 logic", logic_pwr_en, 1);
        check("R1 cache", cache_pwr_en, 1);
        check("R1 iso", coh_iso, 0);
        check("R1 rst", core_rst, 0);
        check("R1 ret", ret_en, 0);

        // R2 R3 R4: shallow depths, every select code, both entries, every source
        for (int d = 0; d < 8; d++) begin
            if (d >= 3 && d <= 5) continue;
            for (int e = 0; e < 2; e++) begin
                for (int s = 0; s < 4; s++) begin
                    automatic int exp_code = (d == 2) ? 2 : 1;
                    enter(d, e);
                    check("R2 clk stop", clk_en, 0);
                    check("R11 code", state_code, exp_code);
                    check("R3 ret_en", ret_en, (d == 2) ? 1 : 0);
                    check("R2 power kept", logic_pwr_en & cache_pwr_en, 1);
                    repeat (2) @(negedge clk);
                    check("R2 held", state_code, exp_code);
                    set_src(s, 1);
                    @(negedge clk);
                    set_src(s, 0);
                    check("R4 first cycle", clk_en, 0);
                    check("R11 wake code", state_code, exp_code);
                    @(negedge clk);
                    check("R4 running", clk_en, 1);
                    check("R4 code", state_code, 0);
                    check("R3 ret off", ret_en, 0);
                end
            end
        end

        // R5 R6 R8 R9 R10: deep depths through full power cycle
        for (int d = 3; d <= 5; d++) begin
            for (int e = 0; e < 2; e++) begin
                automatic int hi = 0;
                enter(d, e);
                check("R5 iso", coh_iso, 1);
                check("R5 clk on", clk_en, 1);
                check("R5 logic on", logic_pwr_en, 1);
                check("R11 deep code", state_code, d);
                if (d == 5) begin
                    irq = 1; evt = 1; sev = 1; snoop_req = 1;
                    @(negedge clk);
                    irq = 0; evt = 0; sev = 0; snoop_req = 0;
                    check("R8 no abort", state_code, 5);
                    check("R8 still iso", coh_iso, 1);
                end
                save_done = 1;
                @(negedge clk);
                save_done = 0;
                check("R5 logic off", logic_pwr_en, 0);
                check("R6 cache", cache_pwr_en, (d == 3) ? 1 : 0);
                check("R9 rst off", core_rst, 1);
                if (d == 5) begin
                    irq = 1; evt = 1; sev = 1; snoop_req = 1;
                    repeat (2) @(negedge clk);
                    irq = 0; evt = 0; sev = 0; snoop_req = 0;
                    check("R8 stays off", logic_pwr_en, 0);
                    bring_up = 1;
                end else begin
                    irq = 1;
                end
                @(negedge clk);
                irq = 0;
                bring_up = 0;
                check("R9 power on", logic_pwr_en, 1);
                check("R9 rst", core_rst, 1);
                check("R9 iso", coh_iso, 1);
                check("R9 clk", clk_en, 0);
                repeat (3) @(negedge clk);
                check("R9 waits", clk_en, 0);
                check("R11 pwrup code", state_code, d);
                pwr_good = 1;
                @(negedge clk);
                check("R10 clk during rst", clk_en, 1);
                for (int i = 0; i < 40 && core_rst; i++) begin
                    hi++;
                    @(negedge clk);
                end
                check("R10 hold cycles", hi, HOLD);
                check("R10 run", state_code, 0);
                check("R10 iso off", coh_iso, 0);
                pwr_good = 0;
            end
        end

        // R7: wake during isolation aborts, even with save_done
        for (int d = 3; d <= 4; d++) begin
            enter(d, 0);
            irq = 1;
            save_done = 1;
            @(negedge clk);
            irq = 0;
            save_done = 0;
            check("R7 code", state_code, 0);
            check("R7 no rst", core_rst, 0);
            check("R7 logic", logic_pwr_en, 1);
            check("R7 iso", coh_iso, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule